// File: doc/BRIEF.md
# Security-Banked Fault Status Slice

This block is a small slice of a processor's system-control register space. It keeps a configurable fault status word and a bus fault address register. The status word has one copy for secure software and one for non-secure software. The eight bus-fault bits, [15:8], exist only once and both states share them. Register-bus requests carry an address, a size code and a secure flag.

Status accesses may be byte, halfword or word wide. Software clears status bits by writing ones to them. A control input decides whether non-secure software may see bus-fault state. When that input is low, a non-secure access finds the shared bus-fault bits and the fault address register read-as-zero and write-ignored. Fault logic sets status bits with single-cycle event pulses.

Responses come back one cycle after the request, on a registered read-data output and a one-cycle error pulse.

Top module: `fault_status_slice`

## Requirements
- R1: After reset, both status copies, the shared bus-fault bits and the fault address register are zero, and `rsp_rdata` and `rsp_err` are 0.
- R2: A status access with `req_secure`=1 sees the secure copy and one with `req_secure`=0 sees the non-secure copy, for every bit outside [15:8].
- R3: Status bits [15:8] are stored once. When the access is permitted (see R4 and R9), they appear in status reads from either bank.
- R4: A non-secure access while `bf_to_ns`=0 reads status bits [15:8] as zero, and its ones written to those bits have no effect.
- R5: The fault address register is a 32-bit read/write register at offset 0xD38, word size only. Secure accesses always reach it. A non-secure access while `bf_to_ns`=0 reads zero and its write is discarded.
- R6: A write to the status word is write-one-to-clear: each 1 clears the addressed stored bit and each 0 leaves it unchanged.
- R7: The status word sits at offset 0xD28. `req_size` is 0 for byte, 1 for halfword and 2 for word. Byte lane L = offset-0xD28 maps to bits [8L+7:8L]. A read returns the selected lanes right-aligned with the upper bits zero, and write data is shifted up by 8L before clearing. A halfword must be at offset 0xD28 or 0xD2A, and a word must be at 0xD28.
- R8: A permitted write-one-to-clear of bits [15:8] clears the single shared copy, whichever bank issues it.
- R9: When `main_ext`=0, any access to the fault address register is an error. Status bits [15:8] then read as zero, and both clears and event sets of those bits are ignored.
- R10: While `evt_set`=1, the ones in `evt_bits` set bits in the bank chosen by `evt_secure`; bits [15:8] go to the shared copy. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: An access with an unmapped offset, `req_size`=3 or a misaligned size gives `rsp_err`=1 for exactly the following cycle with `rsp_rdata`=0, and it changes no state.
- R12: `rsp_rdata` carries the read result in the cycle after a valid read and is 0 after any cycle without a valid, error-free read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_ext | input | 1 | Configuration: fault address register and bus-fault bits present |
| bf_to_ns | input | 1 | Control: bus-fault state visible to non-secure accesses |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_secure | input | 1 | Access security attribute |
| req_addr | input | 12 | Register offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, right-aligned |
| evt_set | input | 1 | Fault event pulse |
| evt_secure | input | 1 | Bank receiving the event |
| evt_bits | input | 32 | Status bits to set |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_err | output | 1 | Bad-offset error pulse |

## Verification
The assertions assume that `main_ext` and `bf_to_ns` are quasi-static. This matters because the hold checks on the shared bits and the fault address register use the control value from the request cycle. The stimulus changes these controls only between requests. The assertions also assume at most one request per cycle, with the address and size stable within that cycle, and the bench drives exactly that. Event pulses may fall in the same cycle as clearing writes. The bench does this on purpose to reach the set-over-clear case, and excludes event cycles from the hold check on the shared bits.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   function automatic logic size_fits_lane(input logic [1:0] sz, input logic [1:0] lane);
      case (acc_size_e'(sz))
         SZ_BYTE: size_fits_lane = 1'b1;
         SZ_HALF: size_fits_lane = ~lane[0];
         SZ_WORD: size_fits_lane = (lane == 2'd0);
         default: size_fits_lane = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/fsr_lane_align.sv
module fsr_lane_align #(
   parameter int DATA_W = 32,
   localparam int NBYTES = DATA_W / 8,
   localparam int LANE_W = $clog2(NBYTES)
) (
   input  logic [LANE_W-1:0] lane,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_aligned,
   output logic [DATA_W-1:0] wr_shifted
);
   logic [DATA_W-1:0] size_mask;
   logic [LANE_W+3:0] nbytes_sel;
   logic [LANE_W+2:0] bit_shift;

   assign nbytes_sel = (LANE_W+4)'(1) << size;
   assign bit_shift  = {lane, 3'b000};

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign size_mask[b*8 +: 8] = (b < int'(nbytes_sel)) ? 8'hFF : 8'h00;
   end

   assign rd_aligned = (rd_word >> bit_shift) & size_mask;
   assign wr_shifted = (wr_data & size_mask) << bit_shift;
endmodule

// File: rtl/fsr_status_store.sv
module fsr_status_store #(
   parameter int DATA_W = 32,
   parameter int SH_LO  = 8,
   parameter int SH_W   = 8,
   localparam logic [DATA_W-1:0] SH_MASK  = {{(DATA_W-SH_W){1'b0}}, {SH_W{1'b1}}} << SH_LO,
   localparam logic [DATA_W-1:0] OWN_MASK = ~SH_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] clr_sec,
   input  logic [DATA_W-1:0] clr_ns,
   input  logic [SH_W-1:0]   clr_sh,
   input  logic [DATA_W-1:0] set_sec,
   input  logic [DATA_W-1:0] set_ns,
   input  logic [SH_W-1:0]   set_sh,
   output logic [DATA_W-1:0] sec_q,
   output logic [DATA_W-1:0] ns_q,
   output logic [SH_W-1:0]   sh_q
);
   if (SH_LO + SH_W > DATA_W) begin : g_bad_field
      $error("shared field exceeds the data width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q <= '0;
         ns_q  <= '0;
         sh_q  <= '0;
      end else begin
         sec_q <= ((sec_q & ~clr_sec) | set_sec) & OWN_MASK;
         ns_q  <= ((ns_q & ~clr_ns) | set_ns) & OWN_MASK;
         sh_q  <= (sh_q & ~clr_sh) | set_sh;
      end
   end

   // R10: a set always lands, even against a simultaneous clear
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_sh != '0) |=> ((sh_q & $past(set_sh)) == $past(set_sh)));

   // R6: a clear without a competing set removes the bit
   a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_sec & ~set_sec & OWN_MASK) != '0) |=> ((sec_q & $past(clr_sec & ~set_sec & OWN_MASK)) == '0));
endmodule

// File: rtl/fsr_fault_addr.sv
module fsr_fault_addr #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_en) q <= wdata;
   end

   // R5: an accepted write is visible next cycle
   a_r5_far_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (q == $past(wdata)));
endmodule

// File: rtl/fault_status_slice.sv
module fault_status_slice #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int STATUS_OFS = 'hD28,
   parameter int FAR_OFS    = 'hD38,
   parameter int SH_LO      = 8,
   parameter int SH_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              main_ext,
   input  logic              bf_to_ns,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_secure,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              evt_set,
   input  logic              evt_secure,
   input  logic [DATA_W-1:0] evt_bits,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);
   import fsr_pkg::*;

   localparam int NBYTES = DATA_W / 8;
   localparam int LANE_W = $clog2(NBYTES);
   localparam logic [ADDR_W-1:0] ST_BASE = ADDR_W'(STATUS_OFS);
   localparam logic [ADDR_W-1:0] FA_BASE = ADDR_W'(FAR_OFS);

   if (DATA_W != 32) begin : g_bad_width
      $error("status slice is built for a 32-bit word");
   end
   if (STATUS_OFS % NBYTES != 0) begin : g_bad_align
      $error("status offset must be word aligned");
   end
   if (FAR_OFS >= (1 << ADDR_W) || STATUS_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("offsets exceed the address width");
   end

   logic [LANE_W-1:0] lane;
   logic              st_hit, far_hit, bad, ns_blocked, sh_allow;
   logic [DATA_W-1:0] sec_q, ns_q, far_q;
   logic [SH_W-1:0]   sh_q;
   logic [DATA_W-1:0] st_word, st_rd, wr_shift, clr_vec;
   logic [DATA_W-1:0] set_vec;

   assign lane       = req_addr[LANE_W-1:0];
   assign st_hit     = (req_addr[ADDR_W-1:LANE_W] == ST_BASE[ADDR_W-1:LANE_W])
                       && size_fits_lane(req_size, lane);
   assign far_hit    = (req_addr == FA_BASE) && (acc_size_e'(req_size) == SZ_WORD) && main_ext;
   assign bad        = req_valid && !st_hit && !far_hit;
   assign ns_blocked = !req_secure && !bf_to_ns;
   assign sh_allow   = main_ext && !ns_blocked;

   assign st_word = (req_secure ? sec_q : ns_q)
                    | (sh_allow ? (DATA_W'(sh_q) << SH_LO) : '0);

   fsr_lane_align #(.DATA_W(DATA_W)) u_align (
      .lane       (lane),
      .size       (req_size),
      .rd_word    (st_word),
      .wr_data    (req_wdata),
      .rd_aligned (st_rd),
      .wr_shifted (wr_shift)
   );

   assign clr_vec = (req_valid && req_write && st_hit) ? wr_shift : '0;
   assign set_vec = evt_set ? evt_bits : '0;

   fsr_status_store #(.DATA_W(DATA_W), .SH_LO(SH_LO), .SH_W(SH_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_sec (req_secure ? clr_vec : '0),
      .clr_ns  (req_secure ? '0 : clr_vec),
      .clr_sh  (sh_allow ? clr_vec[SH_LO +: SH_W] : '0),
      .set_sec (evt_secure ? set_vec : '0),
      .set_ns  (evt_secure ? '0 : set_vec),
      .set_sh  (main_ext ? set_vec[SH_LO +: SH_W] : '0),
      .sec_q   (sec_q),
      .ns_q    (ns_q),
      .sh_q    (sh_q)
   );

   fsr_fault_addr #(.DATA_W(DATA_W)) u_far (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (req_valid && req_write && far_hit && !ns_blocked),
      .wdata (req_wdata),
      .q     (far_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_err <= bad;
         if (req_valid && !req_write && st_hit)
            rsp_rdata <= st_rd;
         else if (req_valid && !req_write && far_hit)
            rsp_rdata <= ns_blocked ? '0 : far_q;
         else
            rsp_rdata <= '0;
      end
   end

   // R11: an error response carries no data
   a_r11_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));

   // R5: blocked non-secure writes leave the fault address untouched
   a_r5_far_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && ns_blocked) |=> $stable(far_q));

   // R4: blocked non-secure writes leave the shared bits untouched
   a_r4_shared_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && ns_blocked && !evt_set) |=> $stable(sh_q));

   // R9: fault address access without the main extension is an error
   a_r9_far_absent_err: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !main_ext && req_addr == FA_BASE) |=> rsp_err);
endmodule

// File: tb/tb_fault_status_slice.sv
module tb_fault_status_slice;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        main_ext = 1'b1, bf_to_ns = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        evt_set = 1'b0, evt_secure = 1'b0;
   logic [31:0] evt_bits = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_err;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   // reference state
   logic [31:0] m_sec = '0, m_ns = '0, m_far = '0;
   logic [7:0]  m_sh = '0;

   always #2.5 clk = ~clk;

   fault_status_slice dut (.*);

   function automatic logic [31:0] smask(input logic [1:0] sz);
      return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // one cycle: drive, predict, clock, compare
   task automatic cyc1(input bit v, input bit w, input bit s, input int addr, input int sz,
                       input logic [31:0] wd, input bit ev, input bit evs,
                       input logic [31:0] eb, input string tag);
      logic [31:0] exp_rd, word, clr, bank;
      bit exp_err, st_ok, far_ok, blk, allow;
      int lane;
      req_valid = v; req_write = w; req_secure = s; req_addr = 12'(addr);
      req_size = 2'(sz); req_wdata = wd; evt_set = ev; evt_secure = evs; evt_bits = eb;
      lane   = addr - 'hD28;
      st_ok  = (lane >= 0 && lane < 4) &&
               ((sz == 0) || (sz == 1 && lane % 2 == 0) || (sz == 2 && lane == 0));
      far_ok = (addr == 'hD38) && (sz == 2) && main_ext;
      blk    = !s && !bf_to_ns;
      allow  = main_ext && !blk;
      exp_err = v && !st_ok && !far_ok;
      exp_rd  = 0;
      clr     = 0;
      if (v && st_ok) begin
         bank = s ? m_sec : m_ns;
         if (allow) bank |= {16'h0, m_sh, 8'h0};
         if (!w) exp_rd = (bank >> (lane * 8)) & smask(2'(sz));
         else clr = (wd & smask(2'(sz))) << (lane * 8);
      end
      if (v && far_ok) begin
         if (!w) exp_rd = blk ? 32'h0 : m_far;
         else if (!blk) m_far = wd;
      end
      if (s) m_sec &= ~clr; else m_ns &= ~clr;
      if (allow) m_sh &= ~clr[15:8];
      if (ev) begin
         if (evs) m_sec |= eb; else m_ns |= eb;
         if (main_ext) m_sh |= eb[15:8];
      end
      m_sec &= 32'hFFFF_00FF;
      m_ns  &= 32'hFFFF_00FF;
      @(posedge clk);
      #1;
      req_valid = 0; evt_set = 0;
      checks++;
      if (rsp_rdata !== exp_rd || rsp_err !== exp_err) begin
         errors++;
         $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                  tag, rsp_rdata, rsp_err, exp_rd, exp_err);
      end
   endtask

   task automatic rd(input bit s, input int a, input int sz, input string tag);
      cyc1(1, 0, s, a, sz, 0, 0, 0, 0, tag);
   endtask
   task automatic wr(input bit s, input int a, input int sz, input logic [31:0] d, input string tag);
      cyc1(1, 1, s, a, sz, d, 0, 0, 0, tag);
   endtask
   task automatic ev(input bit s, input logic [31:0] b, input string tag);
      cyc1(0, 0, 0, 0, 0, 0, 1, s, b, tag);
   endtask

   initial begin
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      rd(1, 'hD28, 2, "R1 secure status after reset");
      rd(0, 'hD28, 2, "R1 non-secure status after reset");
      rd(1, 'hD38, 2, "R1 fault address after reset");
      ev(1, 32'h0000_0081, "R10 secure event");
      ev(0, 32'h0001_0002, "R10 non-secure event");
      ev(1, 32'h0000_2300, "R10 shared event");
      rd(1, 'hD28, 2, "R2 R3 secure view");
      rd(0, 'hD28, 2, "R2 R3 non-secure view");
      bf_to_ns = 0;
      rd(0, 'hD28, 2, "R4 non-secure shared hidden");
      rd(0, 'hD29, 0, "R4 non-secure shared byte hidden");
      wr(0, 'hD29, 0, 32'hFF, "R4 blocked clear ignored");
      rd(1, 'hD29, 0, "R4 shared intact");
      rd(1, 'hD28, 0, "R7 byte lane 0");
      rd(0, 'hD2A, 0, "R7 byte lane 2");
      rd(0, 'hD2A, 1, "R7 upper halfword");
      rd(1, 'hD28, 1, "R7 lower halfword");
      bf_to_ns = 1;
      wr(0, 'hD29, 0, 32'h01, "R8 non-secure clear of shared");
      rd(1, 'hD28, 2, "R8 secure sees shared clear");
      wr(1, 'hD28, 1, 32'h2000, "R8 secure clear of shared");
      rd(0, 'hD29, 0, "R8 non-secure sees shared clear");
      wr(1, 'hD28, 2, 32'h0000_0001, "R6 clear one bit");
      rd(1, 'hD28, 2, "R6 other bits kept");
      wr(0, 'hD2A, 1, 32'h0000, "R6 zeros no effect");
      rd(0, 'hD28, 2, "R6 non-secure unchanged");
      cyc1(1, 1, 1, 'hD28, 2, 32'h80, 1, 1, 32'h80, "R10 set beats clear");
      rd(1, 'hD28, 2, "R10 bit still set");
      wr(1, 'hD38, 2, 32'h1234_5678, "R5 secure write address");
      bf_to_ns = 0;
      rd(0, 'hD38, 2, "R5 blocked read zero");
      wr(0, 'hD38, 2, 32'hDEAD_BEEF, "R5 blocked write");
      rd(1, 'hD38, 2, "R5 secure read kept");
      bf_to_ns = 1;
      wr(0, 'hD38, 2, 32'hCAFE_0001, "R5 allowed non-secure write");
      rd(0, 'hD38, 2, "R5 allowed non-secure read");
      rd(1, 'hD30, 2, "R11 unmapped offset");
      rd(1, 'hD28, 3, "R11 bad size");
      wr(1, 'hD29, 1, 32'hFFFF, "R11 misaligned half");
      rd(1, 'hD2A, 2, "R11 misaligned word");
      rd(1, 'hD38, 1, "R11 narrow address access");
      rd(1, 'hD28, 2, "R11 state unchanged");
      cyc1(0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 idle data zero");
      ev(0, 32'h0000_4000, "R9 shared set before absent");
      main_ext = 0;
      rd(1, 'hD38, 2, "R9 address absent");
      wr(1, 'hD38, 2, 32'h1, "R9 address write absent");
      rd(1, 'hD28, 2, "R9 shared hidden");
      ev(1, 32'h0000_0800, "R9 shared set ignored");
      wr(1, 'hD29, 0, 32'hFF, "R9 shared clear ignored");
      main_ext = 1;
      rd(0, 'hD29, 0, "R9 shared back intact");
      for (int i = 0; i < 400; i++) begin
         int a;
         a = ($urandom % 5 == 0) ? 'hD38 : ('hD28 + int'($urandom % 4));
         if (i % 50 == 0) bf_to_ns = $urandom % 2;
         cyc1($urandom % 4 != 0, $urandom % 3 == 0, $urandom % 2, a, $urandom % 4,
              $urandom, $urandom % 3 == 0, $urandom % 2, $urandom & 32'h0303_0303,
              "R2 R6 R7 random mix");
      end
      summary();
   end
endmodule